// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries a simple 32-bit core from normal execution into the handler of one of two prioritised external interrupt levels, a high level and a low level. In the idle state it compares the two request lines with a global mask and one mask per level, taken from the status word. A level is accepted only when neither mask blocks it. If both levels qualify in the same cycle, the high level is taken. Acceptance does not follow the instruction stream, so the sequencer then waits for the core to report that its pipeline has drained.

When the pipeline has drained, the sequencer pushes a fixed frame of eight words to a descending stack, one word per cycle, through a word-wide write port. After the last write it presents a new status word, a new program counter and a new stack pointer, and pulses a completion strobe. The new status word raises the level masks, sets a mode code for the level, and clears two flags. The new program counter is a vector base plus an offset supplied by the external interrupt controller. Any request that arrives while a sequence is running is ignored.

Status word layout used throughout: flag R at bit 15, global mask at bit 16, level masks for levels 0..3 at bits 17..20, a 3-bit mode field at bits 24:22, and flag J at bit 28. The high level is level 3 and the low level is level 2.

Top module: `irq_entry_seq`

## Requirements
- R1: While idle, a high request is accepted only when status bits 16 and 20 are both 0, and a low request only when bits 16 and 19 are both 0. A masked request causes no stack write and leaves `busy` low.
- R2: When both levels qualify in the same idle cycle, the high level is accepted.
- R3: After acceptance `busy` is high and no stack write occurs while `pipe_drained` is low. In the first cycle that `pipe_drained` is sampled high, the register values are captured, and writes begin in the next cycle.
- R4: The frame is eight writes on consecutive cycles. Write k (k = 0..7) goes to `sp_in - 4*(k+1)`, where `sp_in` is sampled at acceptance. The data order is R8, R9, R10, R11, R12 (`save_regs` bits [32k+31:32k], k = 0..4), then LR (`save_regs` slice 5), then `ret_pc`, then the status word.
- R5: The status word pushed in the last write is the `sr_in` value sampled at acceptance, before any updates.
- R6: On high-level entry, `sr_out` equals the saved status word with bits 17..20 set to 1, bits 24:22 set to 101, bits 15 and 28 cleared, and all other bits unchanged.
- R7: On low-level entry, `sr_out` equals the saved status word with bits 17..19 set to 1, bit 20 unchanged, bits 24:22 set to 100, bits 15 and 28 cleared, and all other bits unchanged.
- R8: `entry_done` is a one-cycle pulse in the cycle after the last write. In that same cycle `sr_out`, `pc_out` (= `vec_base` + zero-extended `vec_offset`, both sampled during the last write) and `sp_out` (= address of the last write) take their new values and then hold until the next entry.
- R9: Requests that arrive while `busy` is high are ignored. Exactly one frame and one `entry_done` pulse are produced per accepted request.
- R10: After synchronous reset, `busy`, `mem_we`, `entry_done`, `sr_out`, `pc_out` and `sp_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_hi | input | 1 | High-level (level 3) request |
| irq_lo | input | 1 | Low-level (level 2) request |
| vec_offset | input | 16 | Handler offset from the interrupt controller |
| vec_base | input | 32 | Exception vector base |
| sr_in | input | 32 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| save_regs | input | 192 | R8..R12 and LR, 32 bits each, R8 lowest |
| ret_pc | input | 32 | PC of the first instruction that did not complete |
| pipe_drained | input | 1 | Pipeline has emptied |
| mem_we | output | 1 | Stack write strobe |
| mem_addr | output | 32 | Stack write address |
| mem_wdata | output | 32 | Stack write data |
| sr_out | output | 32 | New status word |
| pc_out | output | 32 | New program counter |
| sp_out | output | 32 | New stack pointer |
| entry_done | output | 1 | Entry complete pulse |
| busy | output | 1 | Sequence in progress |

## Verification
The hardest situation to reach from the ports is a competing request that arrives in the middle of a running sequence. A low-level entry is started with the global mask and level-3 mask clear, and the high request is then held asserted through both the drain wait and the push. If that request were not ignored, it would show up as a second frame or a level-3 mode code. The drain wait is stretched over several cycles so the bench can confirm, cycle by cycle, that no write leaks out before `pipe_drained` rises.

// File: rtl/irq_entry_pkg.sv
// Package: shared constants and types for the interrupt entry sequencer.
// Assumes a 32-bit status word with the bit layout given below.
package irq_entry_pkg;
    localparam int FRAME_WORDS = 8;
    localparam int IDX_W       = $clog2(FRAME_WORDS);

    localparam int SR_R_BIT    = 15;
    localparam int SR_GM_BIT   = 16;
    localparam int SR_M0_BIT   = 17;
    localparam int SR_M1_BIT   = 18;
    localparam int SR_M2_BIT   = 19;
    localparam int SR_M3_BIT   = 20;
    localparam int SR_MODE_LSB = 22;
    localparam int SR_J_BIT    = 28;

    localparam logic [2:0] MODE_LVL_HI = 3'b101;
    localparam logic [2:0] MODE_LVL_LO = 3'b100;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_PUSH  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/irq_accept.sv
// Module: irq_accept
// Decides combinationally whether a request is accepted this cycle and which level wins.
// Assumes sr holds the live status word; the high level has priority over the low level.
module irq_accept
    import irq_entry_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          req_hi,
    input  logic          req_lo,
    input  logic [DW-1:0] sr,
    output logic          take,
    output logic          take_hi
);
    logic ok_hi;
    logic ok_lo;

    // Check each level against the global mask and its own level mask.
    always_comb begin
        ok_hi   = req_hi && !sr[SR_GM_BIT] && !sr[SR_M3_BIT];
        ok_lo   = req_lo && !sr[SR_GM_BIT] && !sr[SR_M2_BIT];
        take    = ok_hi || ok_lo;
        take_hi = ok_hi;
    end
endmodule

// File: rtl/irq_sr_update.sv
// Module: irq_sr_update
// Builds the status word that takes effect once entry completes.
// Assumes sr_old is the word saved at acceptance and lvl_hi selects the level.
module irq_sr_update
    import irq_entry_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] sr_old,
    input  logic          lvl_hi,
    output logic [DW-1:0] sr_new
);
    // Raise the masks, set the mode code and clear the R and J flags.
    always_comb begin
        sr_new = sr_old;
        sr_new[SR_R_BIT]  = 1'b0;
        sr_new[SR_J_BIT]  = 1'b0;
        sr_new[SR_M0_BIT] = 1'b1;
        sr_new[SR_M1_BIT] = 1'b1;
        sr_new[SR_M2_BIT] = 1'b1;
        if (lvl_hi) begin
            sr_new[SR_M3_BIT] = 1'b1;
            sr_new[SR_MODE_LSB +: 3] = MODE_LVL_HI;
        end else begin
            sr_new[SR_MODE_LSB +: 3] = MODE_LVL_LO;
        end
    end
endmodule

// File: rtl/irq_frame_push.sv
// Module: irq_frame_push
// Captures a frame of words on start, then writes one word per cycle to a
// pre-decremented descending stack, lowest frame index first.
// Assumes start is never raised while a push is already running.
module irq_frame_push
    import irq_entry_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [DW-1:0]           sp_start,
    input  logic [FRAME_WORDS*DW-1:0] words_in,
    output logic                    we,
    output logic [DW-1:0]           addr,
    output logic [DW-1:0]           wdata,
    output logic                    last
);
    localparam logic [DW-1:0]    STEP     = DW'(DW / 8);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

    logic                active;
    logic [IDX_W-1:0]    idx;
    logic [DW-1:0]       sp_q;
    logic [DW-1:0]       frame_q [FRAME_WORDS];

    // Advance the write index and the stack pointer once per written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            sp_q   <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
            sp_q   <= sp_start - STEP;
        end else if (active) begin
            sp_q <= sp_q - STEP;
            idx  <= idx + 1'b1;
            if (idx == LAST_IDX) begin
                active <= 1'b0;
            end
        end
    end

    // Take a snapshot of the frame when the push starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < FRAME_WORDS; i++) frame_q[i] <= '0;
        end else if (start) begin
            for (int i = 0; i < FRAME_WORDS; i++) frame_q[i] <= words_in[i*DW +: DW];
        end
    end

    // Drive the write port from the current index.
    always_comb begin
        we    = active;
        addr  = sp_q;
        wdata = frame_q[idx];
        last  = active && (idx == LAST_IDX);
    end

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && $past(we)) |-> (addr == $past(addr) - STEP));
    // R4
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(idx) == LAST_IDX));
endmodule

// File: rtl/irq_entry_seq.sv
// Module: irq_entry_seq (top)
// Accepts an external interrupt, waits for the pipeline to drain, pushes the
// eight-word frame, then commits the new SR, PC and SP with a done pulse.
// Assumes vec_base and vec_offset are valid during the last frame write.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int DW    = 32,
    parameter int OFF_W = 16,
    parameter int NREGS = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_hi,
    input  logic               irq_lo,
    input  logic [OFF_W-1:0]   vec_offset,
    input  logic [DW-1:0]      vec_base,
    input  logic [DW-1:0]      sr_in,
    input  logic [DW-1:0]      sp_in,
    input  logic [NREGS*DW-1:0] save_regs,
    input  logic [DW-1:0]      ret_pc,
    input  logic               pipe_drained,
    output logic               mem_we,
    output logic [DW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    output logic [DW-1:0]      sr_out,
    output logic [DW-1:0]      pc_out,
    output logic [DW-1:0]      sp_out,
    output logic               entry_done,
    output logic               busy
);
    seq_state_t state;
    logic       take;
    logic       take_hi;
    logic       lvl_hi_q;
    logic [DW-1:0] sr_snap;
    logic [DW-1:0] sp_snap;
    logic [DW-1:0] sr_next;
    logic       push_start;
    logic       push_last;
    logic [FRAME_WORDS*DW-1:0] frame_words;

    irq_accept #(.DW(DW)) u_accept (
        .req_hi (irq_hi),
        .req_lo (irq_lo),
        .sr     (sr_in),
        .take   (take),
        .take_hi(take_hi)
    );

    irq_sr_update #(.DW(DW)) u_sr_upd (
        .sr_old(sr_snap),
        .lvl_hi(lvl_hi_q),
        .sr_new(sr_next)
    );

    // Assemble the frame: saved registers, then return PC, then the saved SR.
    always_comb begin
        frame_words = {sr_snap, ret_pc, save_regs};
    end

    // Start the push in the first cycle in which the drain is seen.
    always_comb begin
        push_start = (state == ST_DRAIN) && pipe_drained;
    end

    irq_frame_push #(.DW(DW)) u_push (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (push_start),
        .sp_start(sp_snap),
        .words_in(frame_words),
        .we      (mem_we),
        .addr    (mem_addr),
        .wdata   (mem_wdata),
        .last    (push_last)
    );

    // Sequence control: accept, wait for drain, push, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            lvl_hi_q   <= 1'b0;
            sr_snap    <= '0;
            sp_snap    <= '0;
            sr_out     <= '0;
            pc_out     <= '0;
            sp_out     <= '0;
            entry_done <= 1'b0;
        end else begin
            entry_done <= 1'b0;
            case (state)
                ST_IDLE: if (take) begin
                    lvl_hi_q <= take_hi;
                    sr_snap  <= sr_in;
                    sp_snap  <= sp_in;
                    state    <= ST_DRAIN;
                end
                ST_DRAIN: if (pipe_drained) state <= ST_PUSH;
                ST_PUSH: if (push_last) begin
                    sr_out     <= sr_next;
                    pc_out     <= vec_base + DW'(vec_offset);
                    sp_out     <= mem_addr;
                    entry_done <= 1'b1;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Report whether a sequence is running.
    always_comb begin
        busy = (state != ST_IDLE);
    end

    // R1
    accept_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(sr_in[SR_GM_BIT]));
    // R3
    drain_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> !mem_we);
    // R8
    done_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> ($past(mem_we) && !mem_we && !busy));
    // R6
    masks_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> (sr_out[SR_M2_BIT] && sr_out[SR_M1_BIT] && sr_out[SR_M0_BIT]
                        && !sr_out[SR_R_BIT] && !sr_out[SR_J_BIT]));
    // R9
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lvl_hi_q));
endmodule

// File: tb/irq_entry_seq_tb.sv
// Directed bench for irq_entry_seq: one task per scenario, each checking its own results.
module irq_entry_seq_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         irq_hi = 1'b0, irq_lo = 1'b0;
    logic [15:0]  vec_offset = '0;
    logic [31:0]  vec_base = '0, sr_in = '0, sp_in = '0, ret_pc = '0;
    logic [191:0] save_regs = '0;
    logic         pipe_drained = 1'b0;
    logic         mem_we, entry_done, busy;
    logic [31:0]  mem_addr, mem_wdata, sr_out, pc_out, sp_out;

    int checks = 0, errors = 0, cycles = 0;
    int wr_cnt = 0, done_cnt = 0;
    logic [31:0] log_addr [16];
    logic [31:0] log_data [16];

    irq_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .irq_hi(irq_hi), .irq_lo(irq_lo),
        .vec_offset(vec_offset), .vec_base(vec_base), .sr_in(sr_in), .sp_in(sp_in),
        .save_regs(save_regs), .ret_pc(ret_pc), .pipe_drained(pipe_drained),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .sr_out(sr_out), .pc_out(pc_out), .sp_out(sp_out),
        .entry_done(entry_done), .busy(busy)
    );

    always #10 clk = ~clk;

    // Log stack writes and done pulses away from the active edge.
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && mem_we) begin
            if (wr_cnt < 16) begin
                log_addr[wr_cnt] <= mem_addr;
                log_data[wr_cnt] <= mem_wdata;
            end
            wr_cnt <= wr_cnt + 1;
        end
        if (rst_n && entry_done) done_cnt <= done_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_sr(input logic [31:0] s, input bit hi);
        logic [31:0] r = s;
        r[15] = 1'b0; r[28] = 1'b0;
        r[17] = 1'b1; r[18] = 1'b1; r[19] = 1'b1;
        if (hi) begin r[20] = 1'b1; r[24:22] = 3'b101; end
        else    r[24:22] = 3'b100;
        return r;
    endfunction

    task automatic clear_log();
        @(negedge clk);
        wr_cnt = 0; done_cnt = 0;
    endtask

    // R10: reset state at the ports.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_we && !entry_done, "R10 control", {29'd0, busy, mem_we, entry_done}, 32'd0);
        chk(sr_out == 0 && pc_out == 0, "R10 sr/pc", sr_out | pc_out, 32'd0);
        chk(sp_out == 0, "R10 sp", sp_out, 32'd0);
        rst_n = 1'b1;
    endtask

    // R1: masked requests produce no activity.
    task automatic t_masked(input logic [31:0] sr, input bit hi, input bit lo, input string tag);
        clear_log();
        sr_in = sr; irq_hi = hi; irq_lo = lo; pipe_drained = 1'b1;
        repeat (10) begin
            @(negedge clk);
            chk(!busy, {"R1 busy ", tag}, {31'd0, busy}, 32'd0);
        end
        irq_hi = 1'b0; irq_lo = 1'b0; pipe_drained = 1'b0;
        @(negedge clk);
        chk(wr_cnt == 0, {"R1 writes ", tag}, wr_cnt, 32'd0);
    endtask

    // R2..R9: full entry with a stretched drain and optional competing request.
    task automatic t_entry(input bit hi, input bit lo, input bit exp_hi, input logic [31:0] sr,
                           input logic [31:0] sp, input int drain_wait, input bit hold_hi, input string tag);
        logic [31:0] exp_w [8];
        bit seen;
        clear_log();
        for (int k = 0; k < 6; k++) save_regs[k*32 +: 32] = 32'h1000_0000 + sp + k;
        ret_pc = sp ^ 32'h00C0_FFEE; vec_base = 32'h8000_0000 ^ sp; vec_offset = sp[15:0] | 16'h0100;
        sr_in = sr; sp_in = sp; irq_hi = hi; irq_lo = lo; pipe_drained = 1'b0;
        @(negedge clk);
        irq_hi = hold_hi; irq_lo = 1'b0;
        sr_in = 32'h0; sp_in = 32'hDEAD_0000;
        for (int c = 0; c < drain_wait; c++) begin
            chk(busy && wr_cnt == 0, {"R3 drain hold ", tag}, wr_cnt, 32'd0);
            @(negedge clk);
        end
        pipe_drained = 1'b1;
        seen = 1'b0;
        for (int c = 0; c < 40 && !seen; c++) begin
            @(negedge clk);
            if (entry_done) seen = 1'b1;
        end
        // Registers change after capture: the frame must keep the captured values.
        for (int k = 0; k < 6; k++) save_regs[k*32 +: 32] = 32'h0;
        irq_hi = 1'b0; pipe_drained = 1'b0;
        chk(seen, {"R8 done seen ", tag}, {31'd0, seen}, 32'd1);
        chk(wr_cnt == 8, {"R4 count ", tag}, wr_cnt, 32'd8);
        for (int k = 0; k < 6; k++) exp_w[k] = 32'h1000_0000 + sp + k;
        exp_w[6] = sp ^ 32'h00C0_FFEE;
        exp_w[7] = sr;
        for (int k = 0; k < 8; k++) begin
            chk(log_addr[k] == sp - 4*(k+1), {"R4 addr ", tag}, log_addr[k], sp - 4*(k+1));
            if (k == 7) chk(log_data[k] == exp_w[k], {"R5 saved sr ", tag}, log_data[k], exp_w[k]);
            else        chk(log_data[k] == exp_w[k], {"R4 data ", tag}, log_data[k], exp_w[k]);
        end
        if (exp_hi) chk(sr_out == exp_sr(sr, 1'b1), {"R6 sr_out ", tag}, sr_out, exp_sr(sr, 1'b1));
        else        chk(sr_out == exp_sr(sr, 1'b0), {"R7 sr_out ", tag}, sr_out, exp_sr(sr, 1'b0));
        chk(pc_out == (32'h8000_0000 ^ sp) + {16'd0, sp[15:0] | 16'h0100}, {"R8 pc ", tag},
            pc_out, (32'h8000_0000 ^ sp) + {16'd0, sp[15:0] | 16'h0100});
        chk(sp_out == sp - 32, {"R8 sp ", tag}, sp_out, sp - 32);
        repeat (6) @(negedge clk);
        chk(done_cnt == 1 && !busy, {"R9 single entry ", tag}, done_cnt, 32'd1);
        chk(wr_cnt == 8, {"R9 no extra writes ", tag}, wr_cnt, 32'd8);
        chk(!entry_done, {"R8 pulse width ", tag}, {31'd0, entry_done}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_masked(32'h0001_0000, 1'b1, 1'b1, "global");
        t_masked(32'h0018_0000, 1'b1, 1'b1, "levels");
        t_entry(1'b1, 1'b0, 1'b1, 32'h1000_8003, 32'h0000_4000, 4, 1'b0, "hi");
        t_entry(1'b1, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_8000, 0, 1'b0, "R2 prio");
        t_entry(1'b0, 1'b1, 1'b0, 32'h1001_8000 & ~32'h0001_0000, 32'h0001_0000, 3, 1'b1, "lo busy");
        t_entry(1'b0, 1'b1, 1'b0, 32'h0010_0005, 32'h0002_0000, 1, 1'b0, "lo m3");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait (cycles > 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected below 100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule